// File: doc/BRIEF.md
# Memory card command and single-block write sequencer

This block sits on the host side of a one-bit memory card bus. Software programs a command index, a 32-bit argument and a control word through a small register bus while the card clock is stopped. Writing the start bit runs the card clock and begins one transaction. The block sends a 48-bit command frame and waits a bounded time for the card's reply. It stores the 48-bit response for byte-wise readback. It can hold completion until the card releases its busy level on the data line, or it can go on to send one data block taken from a 32-byte transmit FIFO.

Completion is reported through sticky interrupt flags. Software clears a flag by writing 1 to it, and a mask register can hide each flag from the interrupt output. The card clock stops by itself when the transaction ends. In this model the card bus advances one bit per system clock while `card_clk_en` is high.

Top module: `card_txn_seq`

## Requirements
- R1: After reset, `card_clk_en`, `cmd_oe`, `dat_oe` and `irq` are low. The flag register (address 8) reads 0, the status register (address 6) reads 0 and the mask register (address 7) reads 3.
- R2: While the card clock runs, writes to the command-index (1), argument (2), control-word (3), block-length (4) and block-count (5) registers are ignored. They read back their earlier values.
- R3: Writing 1 to bit 0 of address 0 starts the clock. From the next cycle, `cmd_o` sends 48 bits MSB first, one per cycle, with `cmd_oe` high: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed, over the first 40 bits) and a final 1.
- R4: With response format (control-word bits 1:0) non-zero, a 0 on `cmd_i` starts a 48-bit reply capture. Six reads of address 9 return the reply MSB byte first. Any further read returns 0.
- R5: If `cmd_i` stays 1 for 64 cycles after the frame ends, the transaction ends with status bit 0 set and the response store empty. A start bit in the 64th waiting cycle is still accepted.
- R6: Flag bit 0 sets when the command phase completes. With response format 0 this happens right after the frame.
- R7: With control-word bit 5 (busy wait) set, flag bit 0 and the clock stop are held back after the reply until `dat_i` is 1.
- R8: With control-word bits 2 (data enable) and 3 (write) set, and after a reply without timeout, a block is sent on `dat_o` once the FIFO (written at address 10) holds the block length in bytes. The block is 0, the bytes MSB first, a CRC16 (polynomial 0x1021, zero seed) and a 1. `cmd_oe` and `dat_oe` are never high together.
- R9: Writing 1 to address 11 makes a waiting write send just the bytes present in the FIFO.
- R10: After the end bit of a block, flag bit 1 sets and the clock stops. Status bit 1 mirrors the clock-running state.
- R11: Flags stay set until 1 is written to them at address 8. `irq` is the OR of the flags whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the response store at address 9) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |
| card_clk_en | output | 1 | Card clock running |
| cmd_o | output | 1 | Command line out |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_i | input | 1 | Command line in |
| dat_o | output | 1 | Data line out |
| dat_oe | output | 1 | Data line drive enable |
| dat_i | input | 1 | Data line in (busy level) |

## Verification
The bench places the card's start bit in the 64th and then the 65th waiting cycle. A design with an off-by-one timer would either time out early and leave the store empty, or accept a reply it should have refused. The argument is rewritten in the middle of a frame; a design that does not freeze its configuration would send or keep the new value. The bench fills the FIFO with one byte fewer than a block and watches for any early start bit on the data line. It also holds the data line low after a busy-wait reply to catch a design that reports completion too soon. A small partial fill then checks that exactly the bytes present are framed with the right CRC16.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  localparam int BUS_AW = 4;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] REG_CTRL   = 4'd0;
  localparam logic [BUS_AW-1:0] REG_CMD    = 4'd1;
  localparam logic [BUS_AW-1:0] REG_ARG    = 4'd2;
  localparam logic [BUS_AW-1:0] REG_CTLW   = 4'd3;
  localparam logic [BUS_AW-1:0] REG_BLKLEN = 4'd4;
  localparam logic [BUS_AW-1:0] REG_NBLK   = 4'd5;
  localparam logic [BUS_AW-1:0] REG_STAT   = 4'd6;
  localparam logic [BUS_AW-1:0] REG_IMASK  = 4'd7;
  localparam logic [BUS_AW-1:0] REG_IFLAG  = 4'd8;
  localparam logic [BUS_AW-1:0] REG_RESP   = 4'd9;
  localparam logic [BUS_AW-1:0] REG_TXDATA = 4'd10;
  localparam logic [BUS_AW-1:0] REG_PART   = 4'd11;

  typedef struct packed {
    logic       init;
    logic       busy_wait;
    logic       stream;
    logic       write;
    logic       data_en;
    logic [1:0] rfmt;
  } cmd_ctl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RWAIT, S_RESP, S_BUSY,
    S_WFILL, S_DSTART, S_DBYTE, S_DCRC, S_DEND
  } seq_state_e;
endpackage

// File: rtl/card_crc_ser.sv
module card_crc_ser #(
  parameter int            W    = 7,
  parameter logic [W-1:0]  POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         sh,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (clr)     crc_d = '0;
    else if (en) crc_d = {crc[W-2:0], 1'b0} ^ ({W{crc[W-1] ^ din}} & POLY);
    else if (sh) crc_d = {crc[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) crc <= '0;
    else        crc <= crc_d;
endmodule

// File: rtl/card_txfifo.sv
module card_txfifo #(
  parameter  int DEPTH = 32,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop  && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
endmodule

// File: rtl/card_txn_seq.sv
module card_txn_seq
  import card_seq_pkg::*;
#(
  parameter int TXF_DEPTH   = 32,
  parameter int RSP_TIMEOUT = 64,
  parameter int BLK_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq,
  output logic              card_clk_en,
  output logic              cmd_o,
  output logic              cmd_oe,
  input  logic              cmd_i,
  output logic              dat_o,
  output logic              dat_oe,
  input  logic              dat_i
);
  localparam int CNT_W = $clog2(TXF_DEPTH + 1);
  localparam int TMR_W = $clog2(RSP_TIMEOUT);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RSP_TIMEOUT - 1);
  localparam logic [5:0] HDR_BITS = 6'd40;
  localparam logic [5:0] LAST_BIT = 6'd47;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  assign rst_n_s = rst_sync[1];

  // configuration and software-visible state
  logic [5:0]       idx_q;
  logic [31:0]      arg_q;
  cmd_ctl_t         ctl_q;
  logic [BLK_W-1:0] blklen_q;
  logic [15:0]      nblk_q;
  logic [1:0]       imask_q, iflag_q, iflag_d;
  logic             tmo_q, part_q;
  logic [2:0]       resp_cnt;

  // sequencer state
  seq_state_e       st, st_d;
  logic             clk_run, run_d;
  logic [5:0]       bit_cnt, cnt_d;
  logic [TMR_W-1:0] tmr, tmr_d;
  logic [39:0]      cmd_sr, csr_d;
  logic [47:0]      resp_sr, rsr_d;
  logic [7:0]       byte_sr, bsr_d;
  logic [CNT_W-1:0] bytes_left, left_d, blk_need;

  logic set_end, set_done, set_tmo, resp_load, fifo_pop, clr_part;
  logic c7_clr, c7_en, c7_sh, c16_clr, c16_en, c16_sh;
  logic [6:0]       crc7_q;
  logic [15:0]      crc16_q;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             wr_cfg, start, fifo_push, resp_pop;

  assign wr_cfg    = bus_wr && !clk_run;
  assign start     = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[0] && !clk_run;
  assign fifo_push = bus_wr && (bus_addr == REG_TXDATA);
  assign resp_pop  = bus_rd && (bus_addr == REG_RESP) && (resp_cnt != 3'd0);

  always_comb begin
    if (blklen_q == '0)                     blk_need = CNT_W'(1);
    else if (blklen_q > BLK_W'(TXF_DEPTH))  blk_need = CNT_W'(TXF_DEPTH);
    else                                    blk_need = blklen_q[CNT_W-1:0];
  end

  card_crc_ser #(.W(7), .POLY(7'h09)) u_crc7 (
    .clk(clk), .rst_n(rst_n_s), .clr(c7_clr), .en(c7_en), .sh(c7_sh),
    .din(cmd_o), .crc(crc7_q));

  card_crc_ser #(.W(16), .POLY(16'h1021)) u_crc16 (
    .clk(clk), .rst_n(rst_n_s), .clr(c16_clr), .en(c16_en), .sh(c16_sh),
    .din(dat_o), .crc(crc16_q));

  card_txfifo #(.DEPTH(TXF_DEPTH), .DW(8)) u_txf (
    .clk(clk), .rst_n(rst_n_s), .push(fifo_push), .din(bus_wdata[7:0]),
    .pop(fifo_pop), .dout(fifo_head), .count(fifo_cnt));

  // sequencer next state
  always_comb begin
    st_d = st; run_d = clk_run; cnt_d = bit_cnt; tmr_d = tmr;
    csr_d = cmd_sr; rsr_d = resp_sr; bsr_d = byte_sr; left_d = bytes_left;
    set_end = 1'b0; set_done = 1'b0; set_tmo = 1'b0; resp_load = 1'b0;
    fifo_pop = 1'b0; clr_part = 1'b0;
    c7_clr = 1'b0; c7_en = 1'b0; c7_sh = 1'b0;
    c16_clr = 1'b0; c16_en = 1'b0; c16_sh = 1'b0;
    cmd_o = 1'b1; cmd_oe = 1'b0; dat_o = 1'b1; dat_oe = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        st_d = S_CMD; run_d = 1'b1; cnt_d = '0;
        csr_d = {2'b01, idx_q, arg_q}; c7_clr = 1'b1;
      end
      S_CMD: begin
        cmd_oe = 1'b1;
        cnt_d  = bit_cnt + 6'd1;
        if (bit_cnt < HDR_BITS) begin
          cmd_o = cmd_sr[39]; c7_en = 1'b1; csr_d = {cmd_sr[38:0], 1'b0};
        end else if (bit_cnt < LAST_BIT) begin
          cmd_o = crc7_q[6]; c7_sh = 1'b1;
        end
        if (bit_cnt == LAST_BIT) begin
          cnt_d = '0; tmr_d = '0;
          if (ctl_q.rfmt == 2'd0) begin
            set_end = 1'b1; run_d = 1'b0; st_d = S_IDLE;
          end else st_d = S_RWAIT;
        end
      end
      S_RWAIT: begin
        if (!cmd_i) begin
          st_d = S_RESP; cnt_d = 6'd1; rsr_d = '0;
        end else if (tmr == TMR_LAST) begin
          set_tmo = 1'b1; set_end = 1'b1; run_d = 1'b0; st_d = S_IDLE;
        end else tmr_d = tmr + TMR_W'(1);
      end
      S_RESP: begin
        rsr_d = {resp_sr[46:0], cmd_i};
        cnt_d = bit_cnt + 6'd1;
        if (bit_cnt == LAST_BIT) begin
          resp_load = 1'b1; cnt_d = '0;
          if (ctl_q.busy_wait) st_d = S_BUSY;
          else if (ctl_q.data_en && ctl_q.write) begin
            set_end = 1'b1; st_d = S_WFILL;
          end else begin
            set_end = 1'b1; run_d = 1'b0; st_d = S_IDLE;
          end
        end
      end
      S_BUSY: if (dat_i) begin
        set_end = 1'b1; run_d = 1'b0; st_d = S_IDLE;
      end
      S_WFILL: if ((part_q && fifo_cnt != '0) || (fifo_cnt >= blk_need)) begin
        st_d = S_DSTART; clr_part = 1'b1;
        left_d = part_q ? fifo_cnt : blk_need;
      end
      S_DSTART: begin
        dat_oe = 1'b1; dat_o = 1'b0;
        bsr_d = fifo_head; fifo_pop = 1'b1; cnt_d = '0; c16_clr = 1'b1;
        st_d = S_DBYTE;
      end
      S_DBYTE: begin
        dat_oe = 1'b1; dat_o = byte_sr[7]; c16_en = 1'b1;
        bsr_d = {byte_sr[6:0], 1'b0};
        cnt_d = bit_cnt + 6'd1;
        if (bit_cnt == 6'd7) begin
          cnt_d  = '0;
          left_d = bytes_left - CNT_W'(1);
          if (bytes_left == CNT_W'(1)) st_d = S_DCRC;
          else begin
            bsr_d = fifo_head; fifo_pop = 1'b1;
          end
        end
      end
      S_DCRC: begin
        dat_oe = 1'b1; dat_o = crc16_q[15]; c16_sh = 1'b1;
        cnt_d = bit_cnt + 6'd1;
        if (bit_cnt == 6'd15) begin
          cnt_d = '0; st_d = S_DEND;
        end
      end
      S_DEND: begin
        dat_oe = 1'b1; dat_o = 1'b1;
        set_done = 1'b1; run_d = 1'b0; st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s)
    if (!rst_n_s) begin
      st <= S_IDLE; clk_run <= 1'b0; bit_cnt <= '0; tmr <= '0;
      cmd_sr <= '0; resp_sr <= '0; byte_sr <= '0; bytes_left <= '0;
    end else begin
      st <= st_d; clk_run <= run_d; bit_cnt <= cnt_d; tmr <= tmr_d;
      cmd_sr <= csr_d; resp_sr <= rsr_d; byte_sr <= bsr_d; bytes_left <= left_d;
    end

  // register file
  always_ff @(posedge clk or negedge rst_n_s)
    if (!rst_n_s) begin
      idx_q <= '0; arg_q <= '0; ctl_q <= '0; blklen_q <= '0; nblk_q <= '0;
    end else if (wr_cfg) begin
      case (bus_addr)
        REG_CMD:    idx_q    <= bus_wdata[5:0];
        REG_ARG:    arg_q    <= bus_wdata;
        REG_CTLW:   ctl_q    <= cmd_ctl_t'(bus_wdata[6:0]);
        REG_BLKLEN: blklen_q <= bus_wdata[BLK_W-1:0];
        REG_NBLK:   nblk_q   <= bus_wdata[15:0];
        default: ;
      endcase
    end

  always_comb begin
    iflag_d = iflag_q;
    if (bus_wr && bus_addr == REG_IFLAG) iflag_d = iflag_q & ~bus_wdata[1:0];
    iflag_d = iflag_d | {set_done, set_end};
  end

  always_ff @(posedge clk or negedge rst_n_s)
    if (!rst_n_s) begin
      imask_q <= 2'b11; iflag_q <= '0; tmo_q <= 1'b0; part_q <= 1'b0; resp_cnt <= '0;
    end else begin
      iflag_q <= iflag_d;
      if (bus_wr && bus_addr == REG_IMASK) imask_q <= bus_wdata[1:0];
      if (start)        tmo_q <= 1'b0;
      else if (set_tmo) tmo_q <= 1'b1;
      if (clr_part) part_q <= 1'b0;
      else if (bus_wr && bus_addr == REG_PART) part_q <= bus_wdata[0];
      if (start)          resp_cnt <= '0;
      else if (resp_load) resp_cnt <= 3'd6;
      else if (resp_pop)  resp_cnt <= resp_cnt - 3'd1;
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL:   bus_rdata = {31'd0, clk_run};
      REG_CMD:    bus_rdata = {26'd0, idx_q};
      REG_ARG:    bus_rdata = arg_q;
      REG_CTLW:   bus_rdata = {25'd0, ctl_q};
      REG_BLKLEN: bus_rdata = BUS_DW'(blklen_q);
      REG_NBLK:   bus_rdata = {16'd0, nblk_q};
      REG_STAT:   bus_rdata = {30'd0, clk_run, tmo_q};
      REG_IMASK:  bus_rdata = {30'd0, imask_q};
      REG_IFLAG:  bus_rdata = {30'd0, iflag_q};
      REG_RESP:   if (resp_cnt != 3'd0)
                    bus_rdata = {24'd0, resp_sr[8*(int'(resp_cnt)-1) +: 8]};
      REG_TXDATA: bus_rdata = BUS_DW'(fifo_cnt);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq         = |(iflag_q & ~imask_q);
  assign card_clk_en = clk_run;
endmodule

// File: rtl/card_txn_seq_chk.sv
module card_txn_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_run,
  input logic        cmd_oe,
  input logic        dat_oe,
  input logic        dat_o,
  input logic [31:0] arg_q,
  input logic [1:0]  iflag,
  input logic        tmo,
  input logic [2:0]  resp_cnt
);
  // R3
  cmd_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> clk_run);

  // R8
  no_line_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_oe && dat_oe));

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run |=> $stable(arg_q));

  // R10
  done_after_end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag[1]) |-> $past(dat_oe && dat_o));

  // R10
  done_stops_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag[1]) |-> !clk_run);

  // R5
  timeout_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> (resp_cnt == 3'd0));
endmodule

bind card_txn_seq card_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .clk_run(clk_run), .cmd_oe(cmd_oe),
  .dat_oe(dat_oe), .dat_o(dat_o), .arg_q(arg_q), .iflag(iflag_q),
  .tmo(tmo_q), .resp_cnt(resp_cnt));

// File: tb/card_txn_seq_tb.sv
module card_txn_seq_tb;
  import card_seq_pkg::*;

  logic        clk, rst_n, bus_wr, bus_rd, cmd_i, dat_i;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, card_clk_en, cmd_o, cmd_oe, dat_o, dat_oe;
  int          checks, errors;
  bit          run_mon;
  logic        exp_cmd[$];
  logic        exp_dat[$];
  logic [7:0]  tx_bytes [32];

  card_txn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .card_clk_en(card_clk_en), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .cmd_i(cmd_i), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: compares each driven line bit against the queue
  always @(negedge clk) if (run_mon) begin
    if (cmd_oe) begin
      if (exp_cmd.size() == 0) chk(1'b0, "R3 unexpected command bit", {31'd0, cmd_o}, 32'hx);
      else begin
        logic b;
        b = exp_cmd.pop_front();
        chk(cmd_o === b, "R3 command bit", {31'd0, cmd_o}, {31'd0, b});
      end
    end
    if (dat_oe) begin
      if (exp_dat.size() == 0) chk(1'b0, "R8 unexpected data bit", {31'd0, dat_o}, 32'hx);
      else begin
        logic b;
        b = exp_dat.pop_front();
        chk(dat_o === b, "R8 data bit", {31'd0, dat_o}, {31'd0, b});
      end
    end
  end

  task automatic push_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] f;
    logic [6:0]  c;
    f = {2'b01, idx, arg};
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      exp_cmd.push_back(f[i]);
      c = {c[5:0], 1'b0} ^ ((c[6] ^ f[i]) ? 7'h09 : 7'h00);
    end
    for (int i = 6; i >= 0; i--) exp_cmd.push_back(c[i]);
    exp_cmd.push_back(1'b1);
  endtask

  task automatic push_dat(input int n);
    logic [15:0] c;
    c = '0;
    exp_dat.push_back(1'b0);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        exp_dat.push_back(tx_bytes[k][i]);
        c = {c[14:0], 1'b0} ^ ((c[15] ^ tx_bytes[k][i]) ? 16'h1021 : 16'h0000);
      end
    for (int i = 15; i >= 0; i--) exp_dat.push_back(c[i]);
    exp_dat.push_back(1'b1);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    bus_read(a, d);
    chk(d === e, req, d, e);
  endtask

  // card model: start bit driven dly negedges after the frame ends
  task automatic card_resp(input int dly, input logic [47:0] r);
    do @(negedge clk); while (!cmd_oe);
    do @(negedge clk); while (cmd_oe);
    repeat (dly - 1) @(negedge clk);
    for (int i = 47; i >= 0; i--) begin
      cmd_i = r[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  task automatic wait_flag(input int bitn, input string req);
    logic [31:0] d;
    int n;
    n = 0;
    do begin
      bus_read(REG_IFLAG, d);
      n++;
    end while (!d[bitn] && n < 400);
    chk(d[bitn] === 1'b1, req, d, 32'(1) << bitn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    checks = 0; errors = 0; run_mon = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmd_i = 1'b1; dat_i = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mon = 1'b1;

    // R1 reset state
    chk(!card_clk_en && !cmd_oe && !dat_oe && !irq, "R1 outputs idle",
        {28'd0, card_clk_en, cmd_oe, dat_oe, irq}, 32'd0);
    expect_reg(REG_IFLAG, 32'd0, "R1 flags");
    expect_reg(REG_STAT,  32'd0, "R1 status");
    expect_reg(REG_IMASK, 32'd3, "R1 mask");

    // R6 no-response command
    bus_write(REG_CMD, 32'd0);
    bus_write(REG_ARG, 32'h0000_0000);
    bus_write(REG_CTLW, 32'h00);
    push_cmd(6'd0, 32'h0);
    bus_write(REG_CTRL, 32'd1);
    wait_flag(0, "R6 end flag without response");
    expect_reg(REG_STAT, 32'd0, "R6 clock stopped");
    bus_write(REG_IFLAG, 32'd3);

    // R4 response capture, R2 mid-frame argument write
    bus_write(REG_CMD, 32'd17);
    bus_write(REG_ARG, 32'hA5C3_0F1E);
    bus_write(REG_CTLW, 32'h01);
    push_cmd(6'd17, 32'hA5C3_0F1E);
    fork
      card_resp(5, 48'h2A_DEAD_BEEF_C1);
      begin
        bus_write(REG_CTRL, 32'd1);
        bus_write(REG_ARG, 32'h1234_5678);
      end
    join
    wait_flag(0, "R6 end flag after response");
    expect_reg(REG_ARG, 32'hA5C3_0F1E, "R2 argument frozen");
    expect_reg(REG_STAT, 32'd0, "R4 no timeout");
    expect_reg(REG_RESP, 32'h2A, "R4 byte0");
    expect_reg(REG_RESP, 32'hDE, "R4 byte1");
    expect_reg(REG_RESP, 32'hAD, "R4 byte2");
    expect_reg(REG_RESP, 32'hBE, "R4 byte3");
    expect_reg(REG_RESP, 32'hEF, "R4 byte4");
    expect_reg(REG_RESP, 32'hC1, "R4 byte5");
    expect_reg(REG_RESP, 32'h00, "R4 empty read");
    bus_write(REG_IFLAG, 32'd3);

    // R5 start bit in 64th waiting cycle is accepted
    push_cmd(6'd17, 32'hA5C3_0F1E);
    fork
      card_resp(64, 48'h11_2233_4455_66);
      bus_write(REG_CTRL, 32'd1);
    join
    wait_flag(0, "R5 boundary end flag");
    expect_reg(REG_STAT, 32'd0, "R5 boundary no timeout");
    expect_reg(REG_RESP, 32'h11, "R5 boundary byte0");
    bus_write(REG_IFLAG, 32'd3);

    // R5 start bit in 65th cycle is too late
    push_cmd(6'd17, 32'hA5C3_0F1E);
    fork
      card_resp(65, 48'h11_2233_4455_66);
      bus_write(REG_CTRL, 32'd1);
    join
    wait_flag(0, "R5 end flag on timeout");
    expect_reg(REG_STAT, 32'd1, "R5 timeout status");
    expect_reg(REG_RESP, 32'h00, "R5 store empty");
    bus_write(REG_IFLAG, 32'd3);

    // R7 busy wait
    bus_write(REG_CMD, 32'd38);
    bus_write(REG_CTLW, 32'h21);
    push_cmd(6'd38, 32'hA5C3_0F1E);
    dat_i = 1'b0;
    fork
      card_resp(3, 48'h26_0000_0900_FF);
      bus_write(REG_CTRL, 32'd1);
    join
    repeat (10) @(negedge clk);
    expect_reg(REG_IFLAG, 32'd0, "R7 held while busy");
    expect_reg(REG_STAT, 32'd2, "R7 clock running while busy");
    dat_i = 1'b1;
    wait_flag(0, "R7 end flag after release");
    expect_reg(REG_STAT, 32'd0, "R7 clock stopped");
    bus_write(REG_IFLAG, 32'd3);

    // R8 full block write, block length 4
    bus_write(REG_CMD, 32'd24);
    bus_write(REG_CTLW, 32'h0D);
    bus_write(REG_BLKLEN, 32'd4);
    bus_write(REG_NBLK, 32'd1);
    push_cmd(6'd24, 32'hA5C3_0F1E);
    fork
      card_resp(2, 48'h18_0000_0900_01);
      bus_write(REG_CTRL, 32'd1);
    join
    wait_flag(0, "R8 response before data");
    tx_bytes[0] = 8'h81; tx_bytes[1] = 8'h00; tx_bytes[2] = 8'hFF; tx_bytes[3] = 8'h3C;
    for (int k = 0; k < 3; k++) bus_write(REG_TXDATA, {24'd0, tx_bytes[k]});
    repeat (20) @(negedge clk);
    expect_reg(REG_IFLAG, 32'd1, "R8 waits for full block");
    push_dat(4);
    bus_write(REG_TXDATA, {24'd0, tx_bytes[3]});
    wait_flag(1, "R10 data done flag");
    expect_reg(REG_STAT, 32'd0, "R10 clock stopped");
    chk(exp_dat.size() == 0, "R8 all data bits sent", exp_dat.size(), 0);

    // R11 interrupt masking and clearing (both flags set)
    chk(irq === 1'b0, "R11 all masked", {31'd0, irq}, 32'd0);
    bus_write(REG_IMASK, 32'd2);
    @(negedge clk);
    chk(irq === 1'b1, "R11 unmasked end flag", {31'd0, irq}, 32'd1);
    bus_write(REG_IFLAG, 32'd1);
    @(negedge clk);
    chk(irq === 1'b0, "R11 cleared end flag", {31'd0, irq}, 32'd0);
    expect_reg(REG_IFLAG, 32'd2, "R11 done flag sticky");
    bus_write(REG_IMASK, 32'd0);
    @(negedge clk);
    chk(irq === 1'b1, "R11 unmasked done flag", {31'd0, irq}, 32'd1);
    bus_write(REG_IFLAG, 32'd2);
    @(negedge clk);
    chk(irq === 1'b0, "R11 all cleared", {31'd0, irq}, 32'd0);

    // R9 partial buffer with block length 32
    bus_write(REG_BLKLEN, 32'd32);
    push_cmd(6'd24, 32'hA5C3_0F1E);
    fork
      card_resp(4, 48'h18_0000_0900_01);
      bus_write(REG_CTRL, 32'd1);
    join
    wait_flag(0, "R9 response before data");
    tx_bytes[0] = 8'h5A; tx_bytes[1] = 8'hC3; tx_bytes[2] = 8'h07;
    for (int k = 0; k < 3; k++) bus_write(REG_TXDATA, {24'd0, tx_bytes[k]});
    repeat (10) @(negedge clk);
    expect_reg(REG_IFLAG, 32'd1, "R9 no send before flag");
    push_dat(3);
    bus_write(REG_PART, 32'd1);
    wait_flag(1, "R9 partial block done");
    chk(irq === 1'b1, "R11 irq on flags", {31'd0, irq}, 32'd1);
    chk(exp_dat.size() == 0, "R9 all partial bits sent", exp_dat.size(), 0);
    chk(exp_cmd.size() == 0, "R3 all command bits sent", exp_cmd.size(), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule